// File: doc/BRIEF.md
# Serial Packet Header Detector

This block monitors a one-bit serial line that is sampled on each rising clock edge. When no packet is present the line carries only zeros. A packet opens with a 10-bit header: a 2-bit start pattern `11` followed by the 8-bit code `11001101`. Both fields arrive most significant bit first. A fixed 24-bit message segment follows the header.

A state machine hunts for the header. When a candidate fails part way, the machine keeps the longest partial match it has already seen, so a header that overlaps a false start is still found. After a full header, the block enters a message window of exactly 24 bit times. In that window it raises the header flag and the message-valid strobe, and it presents the index of the current message bit. On the last message bit it pulses an end-of-packet strobe. The machine then returns to hunting, which allows a new packet to follow back to back.

Top module: `pkt_hdr_det`

## Requirements
- R1: An asynchronous active-low reset drives `header_o`, `msg_bit_valid_o` and `packet_end_o` to 0 and `msg_idx_o` to 0, and it discards any partial header match. This holds even when reset is applied in the middle of a message.
- R2: `header_o` rises in the clock cycle after the edge that samples the tenth header bit. The header bits are the sequence 1,1,1,1,0,0,1,1,0,1 in line order, and no earlier bit is part of the match.
- R3: Once raised, `header_o` and `msg_bit_valid_o` both stay high for exactly 24 cycles, one cycle per message bit on `data_i`, and then fall.
- R4: During the message window, `msg_idx_o` reads 0 for the first message bit and increases by one per cycle up to 23. Outside the window it reads 0.
- R5: `packet_end_o` is high for exactly one cycle, the cycle in which `msg_idx_o` is 23. In the following cycle `header_o` is low.
- R6: A mismatch during hunting keeps the longest suffix of the received bits that is also a header prefix. Examples are extra leading ones, or a false start that shares its tail with a real header.
- R7: Message contents never change the framing. A header pattern carried inside the message neither restarts nor extends the window.
- R8: An all-zero idle line never raises `header_o`.
- R9: Hunting resumes on the first bit after the message window, so a header that starts right after `packet_end_o` is detected.
- R10: A header with any single bit inverted, followed by idle zeros, is not detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, rising edge samples `data_i` |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial data line |
| header_o | output | 1 | High from header detection to packet end |
| msg_bit_valid_o | output | 1 | High while `data_i` carries a message bit |
| msg_idx_o | output | 5 | Index of the current message bit, 0 outside the window |
| packet_end_o | output | 1 | One-cycle strobe on the last message bit |

## Verification
The bench builds the block with its default parameters: a 2-bit start pattern, an 8-bit code and a 24-bit message. These are the values whose overlap structure matters. The start pattern `11` combined with a code that begins `11` creates a self-overlapping prefix, and random streams with inserted headers reach those fallback paths. Directed sequences add back-to-back packets, headers embedded in a payload, every single-bit corruption of the header, and a reset in the middle of a packet.

// File: rtl/pkt_det_pkg.sv
package pkt_det_pkg;

  // Longest suffix of (first k pattern bits, then bit b) that is also a pattern prefix.
  // Pattern bit order: pat[w-1] is the first bit on the line.
  function automatic int unsigned kmp_next(input logic [63:0] pat, input int unsigned w,
                                           input int unsigned k, input logic b);
    logic [64:0] seq;
    int unsigned res;
    logic ok;
    seq = '0;
    res = 0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < k) seq[i] = pat[w-1-i];
    end
    seq[k] = b;
    for (int unsigned len = 1; len <= 64; len++) begin
      if (len <= k + 1 && len <= w) begin
        ok = 1'b1;
        for (int unsigned i = 0; i < 64; i++) begin
          if (i < len && seq[k+1-len+i] != pat[w-1-i]) ok = 1'b0;
        end
        if (ok) res = len;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/hdr_match.sv
module hdr_match #(
  parameter int unsigned      HDR_W   = 10,
  parameter logic [HDR_W-1:0] HDR_PAT = 10'b11_1100_1101
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int unsigned KW = $clog2(HDR_W + 1);
  localparam int unsigned NS = 1 << KW;

  logic [KW-1:0] tab0 [NS];
  logic [KW-1:0] tab1 [NS];
  logic [KW-1:0] k_q, k_d, nxt;

  for (genvar g = 0; g < NS; g++) begin : g_tab
    if (g < HDR_W) begin : g_live
      localparam int unsigned N0 = pkt_det_pkg::kmp_next(64'(HDR_PAT), HDR_W, g, 1'b0);
      localparam int unsigned N1 = pkt_det_pkg::kmp_next(64'(HDR_PAT), HDR_W, g, 1'b1);
      assign tab0[g] = KW'(N0);
      assign tab1[g] = KW'(N1);
    end else begin : g_pad
      assign tab0[g] = '0;
      assign tab1[g] = '0;
    end
  end

  always_comb begin
    nxt   = bit_i ? tab1[k_q] : tab0[k_q];
    hit_o = en_i && (nxt == KW'(HDR_W));
    if (!en_i || hit_o) k_d = '0;
    else                k_d = nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) k_q <= '0;
    else         k_q <= k_d;
  end

  // R6: partial match depth never reaches a full header while held
  p_depth_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_q < KW'(HDR_W));
  // R9: hunting always restarts from an empty match
  p_idle_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> k_q == '0);
endmodule

// File: rtl/msg_window.sv
module msg_window #(
  parameter int unsigned MSG_LEN = 24,
  localparam int unsigned IDX_W  = $clog2(MSG_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  assign active_o = active_q;
  assign idx_o    = idx_q;
  assign last_o   = active_q && (idx_q == IDX_W'(MSG_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (active_q) begin
      if (last_o) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end
  end

  // R4: index advances by one each message cycle
  p_idx_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !last_o) |=> (active_q && idx_q == IDX_W'($past(idx_q) + 1'b1)));
  // R4: index rests at zero outside the window
  p_idx_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> idx_q == '0);
endmodule

// File: rtl/pkt_hdr_det.sv
module pkt_hdr_det #(
  parameter int unsigned        START_W   = 2,
  parameter logic [START_W-1:0] START_PAT = 2'b11,
  parameter int unsigned        CODE_W    = 8,
  parameter logic [CODE_W-1:0]  CODE_PAT  = 8'b1100_1101,
  parameter int unsigned        MSG_LEN   = 24,
  localparam int unsigned       IDX_W     = $clog2(MSG_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  output logic             header_o,
  output logic             msg_bit_valid_o,
  output logic [IDX_W-1:0] msg_idx_o,
  output logic             packet_end_o
);
  localparam int unsigned      HDR_W   = START_W + CODE_W;
  localparam logic [HDR_W-1:0] HDR_PAT = {START_PAT, CODE_PAT};

  logic hit, active, last;

  hdr_match #(
    .HDR_W  (HDR_W),
    .HDR_PAT(HDR_PAT)
  ) i_hdr_match (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (!active),
    .bit_i (data_i),
    .hit_o (hit)
  );

  msg_window #(
    .MSG_LEN(MSG_LEN)
  ) i_msg_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (hit),
    .active_o(active),
    .idx_o   (msg_idx_o),
    .last_o  (last)
  );

  assign header_o        = active;
  assign msg_bit_valid_o = active;
  assign packet_end_o    = last;

  // R2: a completed header opens the window at index zero
  p_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (header_o && msg_idx_o == '0));
  // R5: window closes right after the end strobe
  p_close_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    packet_end_o |=> !header_o);
  // R5: end strobe lasts one cycle
  p_end_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    packet_end_o |=> !packet_end_o);
  // R7: no header match is reported inside a message
  p_no_retrig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    header_o |-> !hit);
endmodule

// File: tb/test_pkt_hdr_det.sv
module test_pkt_hdr_det;
  localparam int unsigned    MSG  = 24;
  localparam logic [9:0]     HDR  = 10'b11_1100_1101;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       data_i = 1'b0;
  logic       header_o, msg_bit_valid_o, packet_end_o;
  logic [4:0] msg_idx_o;

  int unsigned errors = 0;
  int unsigned checks = 0;
  bit          done = 1'b0;

  // reference model
  bit          m_active;
  int unsigned m_idx;
  logic [9:0]  m_hist;
  int unsigned m_cnt;
  string       phase;

  always #2.5 clk_i = ~clk_i;

  pkt_hdr_det i_pkt_hdr_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .header_o(header_o), .msg_bit_valid_o(msg_bit_valid_o),
    .msg_idx_o(msg_idx_o), .packet_end_o(packet_end_o)
  );

  function automatic int unsigned exp_idx();
    return m_active ? m_idx : 0;
  endfunction

  function automatic bit exp_end();
    return m_active && (m_idx == MSG - 1);
  endfunction

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d t=%0t", req, phase, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_active = 0; m_idx = 0; m_hist = '0; m_cnt = 0;
  endtask

  task automatic model_step(input logic b);
    if (m_active) begin
      if (m_idx == MSG - 1) begin
        m_active = 0; m_idx = 0; m_hist = '0; m_cnt = 0;
      end else m_idx++;
    end else begin
      m_hist = {m_hist[8:0], b};
      m_cnt++;
      if (m_cnt >= 10 && m_hist == HDR) begin
        m_active = 1; m_idx = 0; m_cnt = 0;
      end
    end
  endtask

  task automatic compare();
    chk("R2", header_o, m_active);
    chk("R3", msg_bit_valid_o, m_active);
    chk("R4", msg_idx_o, exp_idx());
    chk("R5", packet_end_o, exp_end());
  endtask

  // at negedge: check state, then present next bit
  task automatic send(input logic b);
    @(negedge clk_i);
    compare();
    data_i = b;
    model_step(b);
  endtask

  task automatic send_hdr();
    for (int i = 9; i >= 0; i--) send(HDR[i]);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send(1'b0);
  endtask

  task automatic send_msg_random();
    for (int i = 0; i < MSG; i++) send(1'($urandom));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    phase = "R1 reset";
    #12;
    chk("R1", header_o, 0); chk("R1", msg_bit_valid_o, 0);
    chk("R1", msg_idx_o, 0); chk("R1", packet_end_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    phase = "R8 idle"; send_zeros(40);

    phase = "R2 basic"; send_hdr(); send_msg_random(); send_zeros(5);

    phase = "R6 extra ones";
    for (int i = 0; i < 3; i++) send(1'b1);
    send_hdr(); send_msg_random(); send_zeros(3);

    phase = "R6 false start";
    for (int i = 9; i >= 4; i--) send(HDR[i]);
    send_hdr(); send_msg_random(); send_zeros(3);

    phase = "R7 header in payload";
    send_hdr();
    for (int i = 9; i >= 0; i--) send(HDR[i]);
    for (int i = 9; i >= 0; i--) send(HDR[i]);
    for (int i = 0; i < MSG - 20; i++) send(1'b1);
    send_zeros(12);

    phase = "R9 back to back";
    send_hdr(); send_msg_random(); send_hdr(); send_msg_random(); send_zeros(3);

    phase = "R10 single flip";
    for (int f = 0; f < 10; f++) begin
      for (int i = 9; i >= 0; i--) send(HDR[i] ^ (i == f));
      send_zeros(12);
      chk("R10", header_o, 0);
    end

    phase = "R1 mid-packet reset";
    send_hdr(); for (int i = 0; i < 7; i++) send(1'b1);
    @(negedge clk_i);
    rst_ni = 1'b0; data_i = 1'b0; model_reset();
    #1;
    chk("R1", header_o, 0); chk("R1", msg_idx_o, 0); chk("R1", packet_end_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    send_zeros(4);

    phase = "R6 random";
    for (int n = 0; n < 3000; n++) begin
      if (!m_active && $urandom_range(0, 19) == 0) send_hdr();
      else send(($urandom_range(0, 9) < 6) ? 1'b1 : 1'b0);
    end
    send_zeros(30);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule